// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timer

This block times programmed-I/O data cycles for a host with two IDE channels, each carrying two drives. Software fills a small byte-wide register file with per-drive timing values. When a request arrives naming a channel, a drive and a direction, the block runs the cycle for that channel in three phases, each counted in bus clocks:

- **Address setup** comes first.
- **Strobe** follows: the read or write strobe is held high for the active count.
- **Recovery** ends the cycle, with a one-cycle completion pulse on its last clock.

The two channels run their own cycles independently. A channel that is mid-cycle holds off any further requests addressed to it.

The primary channel keeps a separate address-setup register for each of its drives. The secondary channel has a single setup register shared by both of its drives. Every drive has its own data-timing register. Timing values are captured at the start of each cycle, so software may rewrite a register at any time without disturbing a cycle already under way.

Top module: `ide_pio_timer`

## Requirements
- R1: The setup phase length comes from bits [7:6] of the drive's setup register: 2'b01 gives 2 clocks, 2'b10 gives 3, 2'b00 gives 4 and 2'b11 gives 5.
- R2: The strobe is high for N clocks, where N is the upper nibble of the drive's data-timing register. A nibble of 0 gives 16 clocks.
- R3: The recovery length comes from the lower nibble of the data-timing register: 0 gives 16 clocks, a value k from 1 to 14 gives k+1 clocks, and 15 gives 1 clock.
- R4: A cycle runs setup, then strobe, then recovery. With req_write=1 the strobe appears on wr_stb of the channel; with req_write=0 it appears on rd_stb. The other strobe stays low.
- R5: cyc_done of the channel is high for exactly the last recovery clock. busy of that channel is low in the following clock.
- R6: After reset, the three setup registers read 0x40, the four data-timing registers read 0x3F, and every busy and strobe output is low.
- R7: Config address map: 0 is the primary drive-0 setup register, 1 is the primary drive-1 setup register, 2 is the shared secondary setup register, and 3..6 are the data-timing registers for primary drive 0, primary drive 1, secondary drive 0 and secondary drive 1. On the primary channel (req_chan=0), each drive (req_drive 0 or 1) uses its own setup register.
- R8: On the secondary channel (req_chan=1), both drives use the setup register at address 2, and each uses its own data-timing register.
- R9: Every register stores and reads back the full written byte. Setup bits [5:0] have no effect on timing. Address 7 reads 0 and ignores writes.
- R10: A request is accepted only in a clock where its channel is not busy. A request made while the channel is busy is dropped and starts no cycle.
- R11: The timing values are taken from the registers in the accept clock. A register write during a cycle does not change that cycle.
- R12: The two channels run at the same time without affecting each other. A request for one channel never starts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address (see R7) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational on cfg_addr |
| req_valid | input | 1 | Cycle request |
| req_chan | input | 1 | Channel: 0 primary, 1 secondary |
| req_drive | input | 1 | Drive select within the channel |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| rd_stb | output | 2 | Read strobe per channel |
| wr_stb | output | 2 | Write strobe per channel |
| cyc_done | output | 2 | Per-channel pulse on the last recovery clock |
| busy | output | 2 | Per-channel cycle in progress |

## Verification
The assertions rely on the request port being honoured as specified: a start reaches a channel engine only while that engine is idle, and req_chan and req_drive are stable in the accept clock. The stimulus keeps to this by waiting, at the falling edge, until the addressed channel shows busy low before raising req_valid, and by dropping req_valid one clock later. The single exception is the deliberate request on a busy channel, which checks that requests are held off. Config writes are issued whenever the test needs them, including in the middle of a cycle, because the block is required to tolerate that.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV
    } phase_e;

    // Two-bit setup field; the ordering is not monotonic in the code value
    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] fld);
        case (fld)
            2'b01:   return CNT_W'(2);
            2'b10:   return CNT_W'(3);
            2'b00:   return CNT_W'(4);
            default: return CNT_W'(5);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] active_clocks(input logic [3:0] nib);
        return (nib == 4'd0) ? CNT_W'(16) : {1'b0, nib};
    endfunction

    function automatic logic [CNT_W-1:0] recov_clocks(input logic [3:0] nib);
        if (nib == 4'd0)
            return CNT_W'(16);
        else if (nib == 4'd15)
            return CNT_W'(1);
        else
            return {1'b0, nib} + CNT_W'(1);
    endfunction

endpackage

// File: rtl/ide_pio_regs.sv
module ide_pio_regs #(
    parameter int          ADDR_W    = 3,
    parameter int          N_CHAN    = 2,
    parameter int          N_DRIVE   = 2,
    parameter logic [7:0]  SETUP_RST = 8'h40,
    parameter logic [7:0]  DATA_RST  = 8'h3F
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [7:0]                        wdata,
    output logic [7:0]                        rdata,
    output logic [N_CHAN*N_DRIVE-1:0][1:0]    setup_fld,
    output logic [N_CHAN*N_DRIVE-1:0][7:0]    data_byte
);
    localparam int N_VIEW  = N_CHAN * N_DRIVE;
    localparam int N_SETUP = N_DRIVE + 1;
    localparam int SHARED  = N_DRIVE;
    localparam int DATA_LO = N_SETUP;
    localparam int DATA_HI = N_SETUP + N_VIEW - 1;

    typedef struct packed {
        logic [N_SETUP-1:0][7:0] setup;
        logic [N_VIEW-1:0][7:0]  data;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            for (int i = 0; i < N_SETUP; i++)
                if (int'(addr) == i) regs_d.setup[i] = wdata;
            for (int i = 0; i < N_VIEW; i++)
                if (int'(addr) == DATA_LO + i) regs_d.data[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SETUP; i++) regs_q.setup[i] <= SETUP_RST;
            for (int i = 0; i < N_VIEW; i++)  regs_q.data[i]  <= DATA_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < N_SETUP; i++)
            if (int'(addr) == i) rdata = regs_q.setup[i];
        for (int i = 0; i < N_VIEW; i++)
            if (int'(addr) == DATA_LO + i) rdata = regs_q.data[i];
    end

    // Per-drive views: primary drives own a setup register, later channels share one
    for (genvar v = 0; v < N_VIEW; v++) begin : g_view
        if (v < N_DRIVE) begin : g_own
            assign setup_fld[v] = regs_q.setup[v][7:6];
        end else begin : g_shared
            assign setup_fld[v] = regs_q.setup[SHARED][7:6];
        end
        assign data_byte[v] = regs_q.data[v];
    end

    AST_SHARED_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) == SHARED) |=>
            (setup_fld[N_VIEW-2] == $past(wdata[7:6]) &&
             setup_fld[N_VIEW-1] == $past(wdata[7:6]))); // R8

    AST_HOLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) > DATA_HI) |=>
            ($stable(setup_fld) && $stable(data_byte))); // R9

endmodule

// File: rtl/ide_pio_engine.sv
module ide_pio_engine
    import ide_pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       write,
    input  logic [1:0] setup_fld,
    input  logic [7:0] data_byte,
    output logic       rd_stb,
    output logic       wr_stb,
    output logic       done,
    output logic       busy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] rec;
        logic             wr;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_SETUP;
                    st_d.cnt = setup_clocks(setup_fld) - ONE;
                    st_d.act = active_clocks(data_byte[7:4]);
                    st_d.rec = recov_clocks(data_byte[3:0]);
                    st_d.wr  = write;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.cnt = st_q.act - ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_ACTIVE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_RECOV;
                    st_d.cnt = st_q.rec - ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            default: begin
                if (st_q.cnt == '0) st_d.ph  = PH_IDLE;
                else                st_d.cnt = st_q.cnt - ONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, act: '0, rec: '0, wr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.ph != PH_IDLE);
    assign rd_stb = (st_q.ph == PH_ACTIVE) && !st_q.wr;
    assign wr_stb = (st_q.ph == PH_ACTIVE) &&  st_q.wr;
    assign done   = (st_q.ph == PH_RECOV) && (st_q.cnt == '0);

    // Strobe run-length monitor
    logic [CNT_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                run_q <= '0;
        else if (rd_stb || wr_stb) run_q <= run_q + ONE;
        else                       run_q <= '0;
    end

    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !wr_stb && run_q != '0) |-> (run_q == st_q.act)); // R2

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R5

    AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)); // R5

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R10

    AST_DONE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_stb && !wr_stb)); // R4

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
    parameter logic [7:0] SETUP_RST = 8'h40,
    parameter logic [7:0] DATA_RST  = 8'h3F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       req_valid,
    input  logic       req_chan,
    input  logic       req_drive,
    input  logic       req_write,
    output logic [1:0] rd_stb,
    output logic [1:0] wr_stb,
    output logic [1:0] cyc_done,
    output logic [1:0] busy
);
    localparam int N_CHAN  = 2;
    localparam int N_DRIVE = 2;
    localparam int N_VIEW  = N_CHAN * N_DRIVE;

    logic [N_VIEW-1:0][1:0] setup_fld;
    logic [N_VIEW-1:0][7:0] data_byte;

    ide_pio_regs #(
        .ADDR_W    (3),
        .N_CHAN    (N_CHAN),
        .N_DRIVE   (N_DRIVE),
        .SETUP_RST (SETUP_RST),
        .DATA_RST  (DATA_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .setup_fld (setup_fld),
        .data_byte (data_byte)
    );

    for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
        localparam int BASE = ch * N_DRIVE;
        logic       start;
        logic [1:0] sel_setup;
        logic [7:0] sel_data;

        assign start     = req_valid && (int'(req_chan) == ch) && !busy[ch];
        assign sel_setup = req_drive ? setup_fld[BASE+1] : setup_fld[BASE];
        assign sel_data  = req_drive ? data_byte[BASE+1] : data_byte[BASE];

        ide_pio_engine u_eng (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start),
            .write     (req_write),
            .setup_fld (sel_setup),
            .data_byte (sel_data),
            .rd_stb    (rd_stb[ch]),
            .wr_stb    (wr_stb[ch]),
            .done      (cyc_done[ch]),
            .busy      (busy[ch])
        );

        AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && int'(req_chan) == ch && !busy[ch]) |=> busy[ch]); // R10

        AST_NO_CROSS_START: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && int'(req_chan) != ch && !busy[ch]) |=> !busy[ch]); // R12
    end

endmodule

// File: tb/ide_pio_timer_test.sv
`timescale 1ns/1ps
module ide_pio_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       req_valid = 1'b0;
    logic       req_chan = 1'b0;
    logic       req_drive = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] rd_stb, wr_stb, cyc_done, busy;

    always #2.5 clk = ~clk;

    ide_pio_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_chan(req_chan), .req_drive(req_drive), .req_write(req_write),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .cyc_done(cyc_done), .busy(busy)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        int s;
        int a;
        int r;
        bit w;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];

    logic [7:0] mset [3];
    logic [7:0] mdat [4];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int e_setup(input logic [7:0] b);
        case (b[7:6])
            2'b01: return 2;
            2'b10: return 3;
            2'b00: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic int e_act(input logic [7:0] b);
        return (b[7:4] == 0) ? 16 : int'(b[7:4]);
    endfunction

    function automatic int e_rec(input logic [7:0] b);
        if (b[3:0] == 0) return 16;
        if (b[3:0] == 15) return 1;
        return int'(b[3:0]) + 1;
    endfunction

    task automatic cfg_write(input int a, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 3) mset[a] = v;
        else if (a < 7) mdat[a-3] = v;
    endtask

    task automatic cfg_check(input int a, input logic [7:0] v, input string tag);
        @(negedge clk);
        cfg_addr = 3'(a);
        #1;
        chk(cfg_rdata == v, tag, $sformatf("readback addr %0d", a),
            int'(cfg_rdata), int'(v));
    endtask

    // Driver: waits for the channel to be idle, requests, queues expectation
    task automatic issue(input bit ch, input bit drv, input bit w);
        exp_t e;
        @(negedge clk);
        while (busy[ch]) @(negedge clk);
        e.s = e_setup(ch ? mset[2] : mset[drv]);
        e.a = e_act(mdat[{ch, drv}]);
        e.r = e_rec(mdat[{ch, drv}]);
        e.w = w;
        if (ch) q1.push_back(e); else q0.push_back(e);
        req_valid = 1'b1; req_chan = ch; req_drive = drv; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy != 2'b00 || q0.size() != 0 || q1.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    int  sc [2] = '{0, 0};
    int  ac [2] = '{0, 0};
    int  rc [2] = '{0, 0};
    bit  seen [2] = '{0, 0};
    bit  dirw [2] = '{0, 0};
    bit  bad_dir [2] = '{0, 0};
    bit  want_idle [2] = '{0, 0};

    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (want_idle[c]) begin
                    chk(!busy[c], "R5", "busy after done", int'(busy[c]), 0);
                    want_idle[c] = 1'b0;
                end
                if (busy[c]) begin
                    if (rd_stb[c] && wr_stb[c]) bad_dir[c] = 1'b1;
                    if (rd_stb[c] || wr_stb[c]) begin
                        if (seen[c] && rc[c] != 0) bad_dir[c] = 1'b1;
                        ac[c]++; seen[c] = 1'b1; dirw[c] = wr_stb[c];
                    end else if (!seen[c]) begin
                        sc[c]++;
                    end else begin
                        rc[c]++;
                    end
                    if (cyc_done[c]) begin
                        exp_t e;
                        bit have;
                        have = (c == 0) ? (q0.size() != 0) : (q1.size() != 0);
                        chk(have, "R10", "unexpected cycle", 1, 0);
                        if (have) begin
                            e = (c == 0) ? q0.pop_front() : q1.pop_front();
                            chk(sc[c] == e.s, "R1", $sformatf("ch%0d setup clocks", c), sc[c], e.s);
                            chk(ac[c] == e.a, "R2", $sformatf("ch%0d strobe clocks", c), ac[c], e.a);
                            chk(rc[c] == e.r, "R3", $sformatf("ch%0d recovery clocks", c), rc[c], e.r);
                            chk(dirw[c] == e.w && !bad_dir[c], "R4",
                                $sformatf("ch%0d strobe direction", c), int'(dirw[c]), int'(e.w));
                        end
                        want_idle[c] = 1'b1;
                        sc[c] = 0; ac[c] = 0; rc[c] = 0; seen[c] = 1'b0; bad_dir[c] = 1'b0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) mset[i] = 8'h40;
        for (int i = 0; i < 4; i++) mdat[i] = 8'h3F;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        chk(busy == 2'b00 && rd_stb == 2'b00 && wr_stb == 2'b00, "R6",
            "outputs idle after reset", int'({busy, rd_stb, wr_stb}), 0);
        for (int a = 0; a < 3; a++) cfg_check(a, 8'h40, "R6");
        for (int a = 3; a < 7; a++) cfg_check(a, 8'h3F, "R6");

        // R4 default read cycle: setup 2, strobe 3, recovery 1
        issue(1'b0, 1'b0, 1'b0);
        drain();

        // R7 R9 primary drive 0 own setup; low bits stored but inert
        cfg_write(0, 8'h95);
        cfg_write(3, 8'h52);
        cfg_check(0, 8'h95, "R9");
        issue(1'b0, 1'b0, 1'b1);
        drain();

        // R7 primary drive 1 untouched by drive 0 writes
        issue(1'b0, 1'b1, 1'b0);
        drain();

        // R1 R2 R3 encoding corners on primary drive 1
        cfg_write(1, 8'h00);
        cfg_write(4, 8'h0F);
        issue(1'b0, 1'b1, 1'b0);
        drain();
        cfg_write(1, 8'hC0);
        cfg_write(4, 8'h70);
        issue(1'b0, 1'b1, 1'b1);
        drain();
        cfg_write(4, 8'hE9);
        issue(1'b0, 1'b1, 1'b0);
        drain();

        // R8 secondary shared setup, separate data
        cfg_write(2, 8'h80);
        cfg_write(5, 8'h24);
        cfg_write(6, 8'h91);
        issue(1'b1, 1'b0, 1'b0);
        drain();
        issue(1'b1, 1'b1, 1'b1);
        drain();

        // R9 unused address reads zero and ignores writes
        cfg_write(7, 8'hFF);
        cfg_check(7, 8'h00, "R9");
        cfg_check(6, 8'h91, "R9");
        cfg_check(2, 8'h80, "R9");

        // R12 both channels overlapping
        issue(1'b0, 1'b0, 1'b1);
        issue(1'b1, 1'b1, 1'b0);
        drain();

        // R11 register write during a cycle leaves it unchanged
        issue(1'b1, 1'b1, 1'b1);
        cfg_write(6, 8'h0A);
        cfg_write(2, 8'h40);
        drain();
        issue(1'b1, 1'b1, 1'b0);
        drain();

        // R10 request on busy channel is dropped
        cfg_write(3, 8'h00);
        issue(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 1'b0; req_drive = 1'b1; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (3) begin
            @(negedge clk);
            chk(busy == 2'b00, "R10", "no cycle from held-off request", int'(busy), 0);
        end

        chk(q0.size() == 0 && q1.size() == 0, "R5", "all cycles completed",
            q0.size() + q1.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule